// File: doc/BRIEF.md
# Stochastic OR Adder with Carry Bank

This block sums probability values that arrive as unary stochastic bitstreams, one bit per clock on each input lane. A plain OR gate loses information whenever two or more lanes carry a 1 in the same cycle, and a multiplexer adder divides the result by the number of lanes. This block does neither. It emits a 1 whenever any lane is 1. It stores the surplus coincident ones in a small counter, called the bank, and emits them on later cycles in which every lane is idle. The output density is therefore the plain sum of the input densities, with no scale factor.

The adder is correct only when the encoded sum stays at or below 1. This holds when the lanes carry entries of one probability distribution. A burst of coincidences can still fill the bank. In that case the bank saturates at its full value and a sticky overflow flag records that ones were discarded. The output is registered, so it follows the inputs by one clock. A clock enable freezes the block and forces the output low.

Top module: `stoch_or_adder`

## Requirements
- R1: A synchronous active-low reset clears the bank to zero, drives the output to 0 and clears the overflow flag.
- R2: With enable high and exactly one lane at 1, the output is 1 on the next clock and the bank keeps its value.
- R3: With enable high and k ≥ 2 lanes at 1, the output is 1 on the next clock and the bank grows by k−1.
- R4: With enable high, all lanes at 0 and a nonzero bank, the output is 1 on the next clock and the bank shrinks by one.
- R5: With enable high, all lanes at 0 and an empty bank, the output is 0 on the next clock.
- R6: The bank saturates at 2^CNT_W−1 and never wraps around.
- R7: The overflow flag goes to 1 in the cycle after an increment that exceeds the bank's headroom. It then stays at 1 until reset.
- R8: With enable low, the output is 0 on the next clock, and the lanes do not change the bank or the flag.
- R9: When no overflow occurs and the bank has been drained, the total number of output ones equals the total number of input ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable; low freezes the block |
| lanes_in | input | NUM_IN | One stochastic bit per input stream |
| sum_out | output | 1 | Registered summed bitstream |
| ovf_flag | output | 1 | Sticky flag: bank saturated and dropped ones |

## Verification
Single-lane pulses on an empty bank, followed by idle cycles, show that passing a bit through does not charge the bank. All-lanes bursts followed by idle cycles show, through the length of the replay tail, that the bank grows by k−1 and not by k. Long all-ones bursts separate saturation from wrap-around: a wrapped bank would replay a short tail, while a saturated one replays exactly the full count. Sparse random traffic with densities summing below 1 checks cycle by cycle against a bench model, and also checks that the totals are conserved once the bank has drained.

// File: rtl/stoch_or_pkg.sv
// Shared types for the stochastic OR adder.
package stoch_or_pkg;
    // Per-cycle decision of the adder.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,  // nothing to emit
        ACT_PASS   = 2'd1,  // one lane high, bank untouched
        ACT_BANK   = 2'd2,  // several lanes high, surplus banked
        ACT_REPLAY = 2'd3   // lanes idle, one banked bit emitted
    } sor_act_e;
endpackage

// File: rtl/sor_popcount.sv
// Counts the lanes at 1 through a chain of partial sums.
// Assumes W is wide enough to hold NUM_IN.
module sor_popcount #(
    parameter int NUM_IN = 2,
    parameter int W      = $clog2(NUM_IN + 1)
) (
    input  logic [NUM_IN-1:0] lanes,
    output logic [W-1:0]      count
);
    logic [W-1:0] partial [NUM_IN+1];

    assign partial[0] = '0;
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chain
        assign partial[gi+1] = partial[gi] + W'(lanes[gi]);
    end
    assign count = partial[NUM_IN];
endmodule

// File: rtl/sor_decide.sv
// Picks the cycle action from the lane count and the bank state.
// Assumes count never exceeds NUM_IN.
module sor_decide
    import stoch_or_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         en,
    input  logic [W-1:0] count,
    input  logic         bank_empty,
    output sor_act_e     act,
    output logic         pulse,
    output logic         add_en,
    output logic [W-1:0] add_amt,
    output logic         sub_en
);
    // Classify the cycle; surplus is count minus one.
    always_comb begin
        act = ACT_IDLE;
        if (en) begin
            if (count == '0)
                act = bank_empty ? ACT_IDLE : ACT_REPLAY;
            else if (count == W'(1))
                act = ACT_PASS;
            else
                act = ACT_BANK;
        end
    end

    assign pulse   = (act != ACT_IDLE);
    assign add_en  = (act == ACT_BANK);
    assign add_amt = add_en ? count - W'(1) : '0;
    assign sub_en  = (act == ACT_REPLAY);
endmodule

// File: rtl/sor_bank.sv
// Saturating bank of coincident ones, with a sticky overflow flag.
// Assumes add_en and sub_en are never both high.
module sor_bank #(
    parameter int CNT_W = 4,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [AW-1:0]    add_amt,
    input  logic             sub_en,
    output logic [CNT_W-1:0] bank,
    output logic             ovf
);
    localparam int SW = ((CNT_W > AW) ? CNT_W : AW) + 1;
    localparam logic [SW-1:0] FULL_W = {{(SW-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [SW-1:0] sum_w;
    logic          over;

    // Wide sum, so that overflow can be detected.
    assign sum_w = SW'(bank) + SW'(add_amt);
    assign over  = sum_w > FULL_W;

    // Bank update: saturating add, or decrement by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
            ovf  <= 1'b0;
        end else if (add_en) begin
            if (over) begin
                bank <= {CNT_W{1'b1}};
                ovf  <= 1'b1;
            end else begin
                bank <= sum_w[CNT_W-1:0];
            end
        end else if (sub_en) begin
            bank <= bank - CNT_W'(1);
        end
    end

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == {CNT_W{1'b1}} && add_en) |=> (bank == {CNT_W{1'b1}}));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_flag_on_over_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && over) |=> ovf);
endmodule

// File: rtl/stoch_or_adder.sv
// OR-style adder of stochastic bitstreams. Coincident ones are banked
// and replayed on idle cycles. Assumes the summed density is <= 1.
module stoch_or_adder
    import stoch_or_pkg::*;
#(
    parameter int NUM_IN = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NUM_IN-1:0] lanes_in,
    output logic              sum_out,
    output logic              ovf_flag
);
    localparam int CW = $clog2(NUM_IN + 1);

    logic [CW-1:0]    count;
    logic [CW-1:0]    add_amt;
    logic [CNT_W-1:0] bank;
    logic             pulse, add_en, sub_en;
    sor_act_e         act;

    sor_popcount #(.NUM_IN(NUM_IN), .W(CW)) u_pop (
        .lanes(lanes_in), .count(count)
    );

    sor_decide #(.W(CW)) u_dec (
        .en(en), .count(count), .bank_empty(bank == '0), .act(act),
        .pulse(pulse), .add_en(add_en), .add_amt(add_amt), .sub_en(sub_en)
    );

    sor_bank #(.CNT_W(CNT_W), .AW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_amt(add_amt),
        .sub_en(sub_en), .bank(bank), .ovf(ovf_flag)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_out <= 1'b0;
        else        sum_out <= pulse;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bank == '0 && !sum_out && !ovf_flag));

    assert_single_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $countones(lanes_in) == 1) |=> (sum_out && bank == $past(bank)));

    assert_multi_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $countones(lanes_in) > 1) |=> sum_out);

    assert_replay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lanes_in == '0 && bank != '0) |=> (sum_out && bank == $past(bank) - CNT_W'(1)));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lanes_in == '0 && bank == '0) |=> !sum_out);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sum_out && $stable(bank) && $stable(ovf_flag)));
endmodule

// File: tb/stoch_or_adder_bench.sv
`timescale 1ns/1ps
module stoch_or_adder_bench;
    localparam int NI  = 3;
    localparam int CW  = 4;
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [NI-1:0] lanes = '0;
    logic          sum_out, ovf_flag;

    int vectors = 0, miscompares = 0;
    int m_bank = 0;
    bit m_out = 0, m_ovf = 0, done = 0;
    int in_ones = 0, out_ones = 0;

    always #4 clk = ~clk;

    stoch_or_adder #(.NUM_IN(NI), .CNT_W(CW)) u_stoch_or_adder (
        .clk(clk), .rst_n(rst_n), .en(en), .lanes_in(lanes),
        .sum_out(sum_out), .ovf_flag(ovf_flag)
    );

    function automatic int ones(input logic [NI-1:0] v);
        int n = 0;
        for (int i = 0; i < NI; i++) n += int'(v[i]);
        return n;
    endfunction

    // Reference next state taken from the requirements.
    function automatic void model_step(input logic [NI-1:0] v, input bit e);
        int k = ones(v);
        if (!e) begin
            m_out = 0;
        end else if (k == 0) begin
            m_out = (m_bank > 0);
            if (m_bank > 0) m_bank--;
        end else begin
            m_out = 1;
            if (m_bank + k - 1 > MAX) begin
                m_bank = MAX;
                m_ovf = 1;
            end else begin
                m_bank = m_bank + k - 1;
            end
        end
    endfunction

    task automatic check(input string req);
        vectors++;
        if (sum_out !== m_out || ovf_flag !== m_ovf) begin
            miscompares++;
            $display("FAIL %s: out=%0b ovf=%0b expected out=%0b ovf=%0b",
                     req, sum_out, ovf_flag, m_out, m_ovf);
        end
    endtask

    // Called at a negedge; drives one cycle and checks at the next negedge.
    task automatic step(input logic [NI-1:0] v, input bit e, input string req);
        lanes = v;
        en = e;
        @(posedge clk);
        model_step(v, e);
        if (e) in_ones += ones(v);
        @(negedge clk);
        if (sum_out) out_ones++;
        check(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        en = 0;
        lanes = '0;
        repeat (2) @(posedge clk);
        m_bank = 0; m_out = 0; m_ovf = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1");
        in_ones = 0;
        out_ones = 0;
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) step('0, 1, req);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        drain(2, "R1");                       // empty bank gives zeros

        // R2: lone ones, bank must stay empty
        step(3'b001, 1, "R2"); step(3'b100, 1, "R2");
        step(3'b010, 1, "R2"); drain(2, "R2");

        // R3: three lanes add two; two lanes add one
        step(3'b111, 1, "R3"); drain(3, "R3");
        step(3'b011, 1, "R3"); drain(2, "R3");

        // R4/R5: replay tail, then silence
        step(3'b111, 1, "R4"); step(3'b101, 1, "R4");
        drain(3, "R4"); drain(2, "R5");

        // R8: frozen while disabled, bank kept
        step(3'b111, 1, "R8");
        for (int i = 0; i < 4; i++) step(3'b111, 0, "R8");
        drain(3, "R8");

        // R6/R7: saturation, sticky flag, full-length replay
        for (int i = 0; i < 9; i++) step(3'b111, 1, "R6");
        drain(MAX + 2, "R6");
        step(3'b001, 1, "R7"); drain(2, "R7");
        do_reset();                           // R1: flag cleared

        // R9: sparse random traffic against the model, then totals
        for (int i = 0; i < 3000; i++) begin
            logic [NI-1:0] v;
            for (int b = 0; b < NI; b++) v[b] = ($urandom_range(0, 4) == 0);
            step(v, ($urandom_range(0, 15) != 0), "R9");
        end
        drain(MAX + 2, "R9");
        vectors++;
        if (m_ovf ? (out_ones >= in_ones) : (out_ones != in_ones)) begin
            miscompares++;
            $display("FAIL R9: output ones=%0d expected %0d (ovf=%0b)",
                     out_ones, in_ones, m_ovf);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule